// File: doc/BRIEF.md
# Four-Beat Double-Rate Burst Memory

This block is a synthesizable behavioural model of a static memory with separate read and write data paths. Every request names one four-word burst and moves four data beats. Each beat is one word. The model runs on a single clock, so two beats pass per cycle. The lower word of each 2-word bus is the even beat and the upper word is the odd beat. A read request and a write request can arrive in the same cycle. Each side needs two cycles to move its four beats, so each side takes a new request every second cycle.

On the write side, a request is sampled first. Its beat pair 0/1 arrives on the next cycle and its beat pair 2/3 on the cycle after that. Each beat has its own active-low byte-lane enables, and each lane is nine bits wide. The burst is stored when its last pair arrives.

On the read side, the data is registered. The read returns beats 0/1 in the cycle after acceptance and beats 2/3 in the cycle after that. A read sees every write that was accepted in an earlier cycle. When the matching write's data is still in flight, that data is forwarded and merged lane by lane over the stored contents. The read bus returns to zero when no read is in progress. An echo strobe flips once for each beat pair that is delivered.

Top module: `qb4_sram`

## Requirements
- R1: After reset, rd_valid, rd_echo and rd_data are 0, and every stored word reads back as 0.
- R2: A read is accepted when rd_sel_n is low in any cycle other than the one right after a read acceptance. In the next cycle rd_data holds beat 0 in bits [W-1:0] and beat 1 in bits [2W-1:W], and in the cycle after that it holds beats 2 and 3. rd_valid is 1 in both cycles.
- R3: rd_sel_n is ignored in the cycle right after a read acceptance.
- R4: A write is accepted when wr_sel_n is low in any cycle other than the one right after a write acceptance, and wr_sel_n is ignored in that cycle. wr_data carries beats 0/1 in the next cycle and beats 2/3 in the cycle after, with the even beat in the low word. wr_data is ignored in all other cycles.
- R5: wr_bmask_n bit (k*L + n) belongs to lane n, bits [9n+8:9n], of the pair's beat k (k = 0 for the low word). When the bit is 0 the lane is written. When it is 1 the lane keeps its previous contents.
- R6: A read returns the contents left by every write accepted in an earlier cycle, including a write whose beats are still arriving. Byte enables are applied exactly as they are for storage.
- R7: A write accepted in the same cycle as a read to the same burst does not affect that read's data.
- R8: If no read is accepted in the cycle that delivers beats 2/3, then rd_valid and rd_data are 0 in the next cycle, and they stay 0 until a read is accepted.
- R9: rd_echo toggles at every clock edge that places a beat pair on rd_data, and holds at every other edge.
- R10: Reads accepted every second cycle keep rd_valid high without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_sel_n | input | 1 | Active-low read request |
| rd_addr | input | ADDR_W | Burst address of the read |
| wr_sel_n | input | 1 | Active-low write request |
| wr_addr | input | ADDR_W | Burst address of the write |
| wr_data | input | 2*WORD_W | Write beat pair, even beat in the low word |
| wr_bmask_n | input | 2*WORD_W/9 | Active-low lane enables for the pair |
| rd_data | output | 2*WORD_W | Read beat pair, even beat in the low word |
| rd_valid | output | 1 | rd_data holds a beat pair |
| rd_echo | output | 1 | Toggles per delivered beat pair |

## Verification
The hardest case to reach is a read that lands while a masked write to the same burst is still arriving. That write's beats may sit in the buffer, on the write bus, or be stored only partly, and all three positions must be covered. The stimulus places a masked write and then a read of the same burst one, two and three cycles later, for every burst. A long run of pseudo-random read and write requests then covers four bursts, so that overlaps and same-cycle pairs happen often. The bench keeps its own copy of the memory and applies each write at the moment the write is accepted. The expected result for a read is therefore just that copy as it stands when the read is accepted.

// File: rtl/qb4_pkg.sv
package qb4_pkg;

    localparam int LANE_BITS = 9;
    localparam int BURST_LEN = 4;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_HEAD = 2'd1,
        RS_TAIL = 2'd2
    } rd_state_e;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_PAIR0 = 2'd1,
        WS_PAIR1 = 2'd2
    } wr_state_e;

endpackage

// File: rtl/qb4_array.sv
module qb4_array
    import qb4_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int WORD_W = 18,
    localparam int LANES  = WORD_W / LANE_BITS,
    localparam int IDX_W  = ADDR_W + 2,
    localparam int DEPTH  = 1 << IDX_W,
    localparam int PAIR_W = 2 * WORD_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             w_addr,
    input  logic [BURST_LEN*WORD_W-1:0]   w_data,
    input  logic [BURST_LEN*LANES-1:0]    w_mask_n,
    input  logic [ADDR_W-1:0]             ra_addr,
    input  logic                          ra_pair,
    output logic [PAIR_W-1:0]             ra_data,
    input  logic [ADDR_W-1:0]             rb_addr,
    input  logic                          rb_pair,
    output logic [PAIR_W-1:0]             rb_data
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            for (int g = 0; g < BURST_LEN * LANES; g++) begin
                if (!w_mask_n[g]) begin
                    mem[{w_addr, 2'(g / LANES)}][(g % LANES)*LANE_BITS +: LANE_BITS]
                        <= w_data[g*LANE_BITS +: LANE_BITS];
                end
            end
        end
    end

    assign ra_data = {mem[{ra_addr, ra_pair, 1'b1}], mem[{ra_addr, ra_pair, 1'b0}]};
    assign rb_data = {mem[{rb_addr, rb_pair, 1'b1}], mem[{rb_addr, rb_pair, 1'b0}]};

endmodule

// File: rtl/qb4_wr_ctrl.sv
module qb4_wr_ctrl
    import qb4_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int WORD_W = 18,
    localparam int LANES   = WORD_W / LANE_BITS,
    localparam int PAIR_W  = 2 * WORD_W,
    localparam int PMASK_W = 2 * LANES
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_sel_n,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [PAIR_W-1:0]              wr_data,
    input  logic [PMASK_W-1:0]             wr_bmask_n,
    output wr_state_e                      state,
    output logic [ADDR_W-1:0]              cur_addr,
    output logic [PAIR_W-1:0]              buf_data,
    output logic [PMASK_W-1:0]             buf_mask_n,
    output logic                           commit,
    output logic [BURST_LEN*WORD_W-1:0]    commit_data,
    output logic [BURST_LEN*LANES-1:0]     commit_mask_n
);

    wr_state_e nxt;
    logic      accept;

    assign accept = !wr_sel_n && (state != WS_PAIR0);

    always_comb begin
        nxt = WS_IDLE;
        unique case (state)
            WS_IDLE:  nxt = accept ? WS_PAIR0 : WS_IDLE;
            WS_PAIR0: nxt = WS_PAIR1;
            WS_PAIR1: nxt = accept ? WS_PAIR0 : WS_IDLE;
            default:  nxt = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= WS_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            buf_data   <= '0;
            buf_mask_n <= '1;
        end else begin
            if (accept) cur_addr <= wr_addr;
            if (state == WS_PAIR0) begin
                buf_data   <= wr_data;
                buf_mask_n <= wr_bmask_n;
            end
        end
    end

    assign commit        = (state == WS_PAIR1);
    assign commit_data   = {wr_data, buf_data};
    assign commit_mask_n = {wr_bmask_n, buf_mask_n};

endmodule

// File: rtl/qb4_fwd_merge.sv
module qb4_fwd_merge
    import qb4_pkg::*;
#(
    parameter int WORD_W = 18,
    localparam int LANES   = WORD_W / LANE_BITS,
    localparam int PAIR_W  = 2 * WORD_W,
    localparam int PMASK_W = 2 * LANES
) (
    input  logic [PAIR_W-1:0]  stored,
    input  logic [PAIR_W-1:0]  fresh,
    input  logic [PMASK_W-1:0] fresh_mask_n,
    input  logic               use_fresh,
    output logic [PAIR_W-1:0]  merged
);

    for (genvar g = 0; g < PMASK_W; g++) begin : g_lane
        assign merged[g*LANE_BITS +: LANE_BITS] =
            (use_fresh && !fresh_mask_n[g]) ? fresh[g*LANE_BITS +: LANE_BITS]
                                            : stored[g*LANE_BITS +: LANE_BITS];
    end

endmodule

// File: rtl/qb4_rd_ctrl.sv
module qb4_rd_ctrl
    import qb4_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int WORD_W = 18,
    localparam int LANES   = WORD_W / LANE_BITS,
    localparam int PAIR_W  = 2 * WORD_W,
    localparam int PMASK_W = 2 * LANES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_sel_n,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [PAIR_W-1:0]   head_stored,
    input  logic [PAIR_W-1:0]   tail_stored,
    input  wr_state_e           wr_state,
    input  logic [ADDR_W-1:0]   wr_cur_addr,
    input  logic [PAIR_W-1:0]   wr_buf_data,
    input  logic [PMASK_W-1:0]  wr_buf_mask_n,
    input  logic [PAIR_W-1:0]   wr_data,
    input  logic [PMASK_W-1:0]  wr_bmask_n,
    output logic [ADDR_W-1:0]   tail_addr,
    output rd_state_e           state,
    output logic [PAIR_W-1:0]   rd_data,
    output logic                rd_valid,
    output logic                rd_echo
);

    rd_state_e          nxt;
    logic               accept;
    logic               hit_head_bus, hit_head_buf, hit_tail_bus;
    logic [PAIR_W-1:0]  head_fresh;
    logic [PMASK_W-1:0] head_fresh_mask_n;
    logic [PAIR_W-1:0]  head_merged, tail_merged;

    assign accept = !rd_sel_n && (state != RS_HEAD);

    // Pending write whose beats 0/1 are on the bus or already buffered.
    assign hit_head_bus = (wr_state == WS_PAIR0) && (wr_cur_addr == rd_addr);
    assign hit_head_buf = (wr_state == WS_PAIR1) && (wr_cur_addr == rd_addr);
    // Pending write whose beats 2/3 are on the bus now.
    assign hit_tail_bus = (wr_state == WS_PAIR1) && (wr_cur_addr == tail_addr);

    assign head_fresh        = hit_head_bus ? wr_data    : wr_buf_data;
    assign head_fresh_mask_n = hit_head_bus ? wr_bmask_n : wr_buf_mask_n;

    qb4_fwd_merge #(.WORD_W(WORD_W)) u_head_merge (
        .stored       (head_stored),
        .fresh        (head_fresh),
        .fresh_mask_n (head_fresh_mask_n),
        .use_fresh    (hit_head_bus || hit_head_buf),
        .merged       (head_merged)
    );

    qb4_fwd_merge #(.WORD_W(WORD_W)) u_tail_merge (
        .stored       (tail_stored),
        .fresh        (wr_data),
        .fresh_mask_n (wr_bmask_n),
        .use_fresh    (hit_tail_bus),
        .merged       (tail_merged)
    );

    always_comb begin
        nxt = RS_IDLE;
        unique case (state)
            RS_IDLE: nxt = accept ? RS_HEAD : RS_IDLE;
            RS_HEAD: nxt = RS_TAIL;
            RS_TAIL: nxt = accept ? RS_HEAD : RS_IDLE;
            default: nxt = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RS_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_addr <= '0;
            rd_data   <= '0;
            rd_valid  <= 1'b0;
            rd_echo   <= 1'b0;
        end else if (accept) begin
            tail_addr <= rd_addr;
            rd_data   <= head_merged;
            rd_valid  <= 1'b1;
            rd_echo   <= ~rd_echo;
        end else if (state == RS_HEAD) begin
            rd_data   <= tail_merged;
            rd_valid  <= 1'b1;
            rd_echo   <= ~rd_echo;
        end else begin
            rd_data   <= '0;
            rd_valid  <= 1'b0;
        end
    end

endmodule

// File: rtl/qb4_sram.sv
module qb4_sram
    import qb4_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int WORD_W = 18,
    localparam int LANES   = WORD_W / LANE_BITS,
    localparam int PAIR_W  = 2 * WORD_W,
    localparam int PMASK_W = 2 * LANES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_sel_n,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                wr_sel_n,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [PAIR_W-1:0]   wr_data,
    input  logic [PMASK_W-1:0]  wr_bmask_n,
    output logic [PAIR_W-1:0]   rd_data,
    output logic                rd_valid,
    output logic                rd_echo
);

    rd_state_e                       rd_st;
    wr_state_e                       wr_st;
    logic [ADDR_W-1:0]               wr_cur_addr, tail_addr;
    logic [PAIR_W-1:0]               wr_buf_data, head_stored, tail_stored;
    logic [PMASK_W-1:0]              wr_buf_mask_n;
    logic                            commit;
    logic [BURST_LEN*WORD_W-1:0]     commit_data;
    logic [BURST_LEN*LANES-1:0]      commit_mask_n;

    qb4_wr_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_wr (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_sel_n      (wr_sel_n),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .wr_bmask_n    (wr_bmask_n),
        .state         (wr_st),
        .cur_addr      (wr_cur_addr),
        .buf_data      (wr_buf_data),
        .buf_mask_n    (wr_buf_mask_n),
        .commit        (commit),
        .commit_data   (commit_data),
        .commit_mask_n (commit_mask_n)
    );

    qb4_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (commit),
        .w_addr   (wr_cur_addr),
        .w_data   (commit_data),
        .w_mask_n (commit_mask_n),
        .ra_addr  (rd_addr),
        .ra_pair  (1'b0),
        .ra_data  (head_stored),
        .rb_addr  (tail_addr),
        .rb_pair  (1'b1),
        .rb_data  (tail_stored)
    );

    qb4_rd_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rd (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_sel_n      (rd_sel_n),
        .rd_addr       (rd_addr),
        .head_stored   (head_stored),
        .tail_stored   (tail_stored),
        .wr_state      (wr_st),
        .wr_cur_addr   (wr_cur_addr),
        .wr_buf_data   (wr_buf_data),
        .wr_buf_mask_n (wr_buf_mask_n),
        .wr_data       (wr_data),
        .wr_bmask_n    (wr_bmask_n),
        .tail_addr     (tail_addr),
        .state         (rd_st),
        .rd_data       (rd_data),
        .rd_valid      (rd_valid),
        .rd_echo       (rd_echo)
    );

endmodule

// File: rtl/qb4_sram_chk.sv
module qb4_sram_chk
    import qb4_pkg::*;
#(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_sel_n,
    input logic          rd_valid,
    input logic          rd_echo,
    input logic [DW-1:0] rd_data,
    input rd_state_e     rd_st,
    input wr_state_e     wr_st
);

    AST_READ_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_sel_n && rd_st != RS_HEAD) |=> rd_valid); // R2

    AST_TWO_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |=> rd_valid); // R2

    AST_HEAD_TO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_st == RS_HEAD) |=> (rd_st == RS_TAIL)); // R3

    AST_WR_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_st == WS_PAIR0) |=> (wr_st == WS_PAIR1)); // R4

    AST_NOP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_st == RS_TAIL && rd_sel_n) |=> !rd_valid); // R8

    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0)); // R8

    AST_ECHO_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_echo != $past(rd_echo))); // R9

    AST_ECHO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_echo)); // R9

endmodule

bind qb4_sram qb4_sram_chk #(.DW(2 * WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_sel_n (rd_sel_n),
    .rd_valid (rd_valid),
    .rd_echo  (rd_echo),
    .rd_data  (rd_data),
    .rd_st    (rd_st),
    .wr_st    (wr_st)
);

// File: tb/tb_qb4_sram.sv
`timescale 1ns/1ps
module tb_qb4_sram;

    localparam int AW    = 4;
    localparam int W     = 18;
    localparam int L     = W / 9;
    localparam int PW    = 2 * W;
    localparam int DEPTH = 4 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_sel_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic          wr_sel_n = 1'b1;
    logic [AW-1:0] wr_addr = '0;
    logic [PW-1:0] wr_data = '0;
    logic [2*L-1:0] wr_bmask_n = '1;
    logic [PW-1:0] rd_data;
    logic          rd_valid;
    logic          rd_echo;

    always #4 clk = ~clk;

    qb4_sram #(.ADDR_W(AW), .WORD_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
        .wr_sel_n(wr_sel_n), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_bmask_n(wr_bmask_n), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_echo(rd_echo)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [31:0] lcg = 32'h1234_5678;

    logic [W-1:0] model [DEPTH];
    logic [W-1:0] pw_data [4];
    logic [L-1:0] pw_mask [4];
    bit           wp0_due = 0, wp1_due = 0;
    bit           rtail_v = 0;
    logic [PW-1:0] rtail_d = '0;
    bit           echo_exp = 0;

    function automatic logic [31:0] rnd();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg ^ (lcg >> 15);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock cycle of stimulus; checks outputs in the following cycle.
    task automatic step(input bit rd, input int ra, input bit wr, input int wa,
                        input bit rmask, input string tag);
        bit            racc, wacc, exp_v;
        logic [PW-1:0] exp_d;
        rd_sel_n = !rd;
        rd_addr  = AW'(ra);
        wr_sel_n = !wr;
        wr_addr  = AW'(wa);
        if (wp0_due) begin
            wr_data    = {pw_data[1], pw_data[0]};
            wr_bmask_n = {pw_mask[1], pw_mask[0]};
        end else if (wp1_due) begin
            wr_data    = {pw_data[3], pw_data[2]};
            wr_bmask_n = {pw_mask[3], pw_mask[2]};
        end else begin
            wr_data    = {4'(rnd()), rnd()};  // R4: ignored outside data cycles
            wr_bmask_n = '0;
        end
        racc = rd && !rtail_v;
        if (racc) begin
            exp_v   = 1'b1;
            exp_d   = {model[ra*4+1], model[ra*4]};
            rtail_d = {model[ra*4+3], model[ra*4+2]};
            rtail_v = 1'b1;
        end else if (rtail_v) begin
            exp_v   = 1'b1;
            exp_d   = rtail_d;
            rtail_v = 1'b0;
        end else begin
            exp_v = 1'b0;
            exp_d = '0;
        end
        wacc    = wr && !wp0_due;
        wp1_due = wp0_due;
        wp0_due = wacc;
        if (wacc) begin
            for (int b = 0; b < 4; b++) begin
                pw_data[b] = W'(rnd());
                pw_mask[b] = rmask ? L'(rnd() >> 7) : '0;
                for (int n = 0; n < L; n++)
                    if (!pw_mask[b][n]) model[wa*4+b][n*9 +: 9] = pw_data[b][n*9 +: 9];
            end
        end
        @(posedge clk);
        @(negedge clk);
        if (exp_v) echo_exp = ~echo_exp;
        chk(rd_valid == exp_v, tag, "rd_valid", 64'(rd_valid), 64'(exp_v));
        chk(rd_data == exp_d, tag, "rd_data", 64'(rd_data), 64'(exp_d));
        chk(rd_echo == echo_exp, "R9", "rd_echo", 64'(rd_echo), 64'(echo_exp));
    endtask

    task automatic nop(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        chk(rd_valid == 1'b0, "R1", "reset rd_valid", 64'(rd_valid), 0);
        chk(rd_data == '0, "R1", "reset rd_data", 64'(rd_data), 0);
        chk(rd_echo == 1'b0, "R1", "reset rd_echo", 64'(rd_echo), 0);
        rst_n = 1'b1;

        // R1 / R2: empty array reads back zero, pair order and timing
        for (int a = 0; a < 4; a++) begin
            step(1, a, 0, 0, 0, "R1");
            step(0, 0, 0, 0, 0, "R2");
        end
        nop(2, "R8");

        // R4: full-lane write sweep, select held every cycle (odd cycles ignored)
        for (int a = 0; a < 16; a++) begin
            step(0, 0, 1, a, 0, "R4");
            step(0, 0, 1, (a + 5) % 16, 0, "R4");
        end
        nop(3, "R4");

        // R10 / R3: back-to-back reads, select held in head cycles
        for (int a = 0; a < 16; a++) begin
            step(1, a, 0, 0, 0, "R10");
            step(1, (a + 3) % 16, 0, 0, 0, "R3");
        end
        nop(3, "R8");

        // R5 / R6: masked write, read of same burst 1..3 cycles later
        for (int a = 0; a < 16; a++) begin
            for (int d = 1; d <= 3; d++) begin
                step(0, 0, 1, a, 1, "R5");
                for (int k = 1; k < d; k++) step(0, 0, 0, 0, 0, "R5");
                step(1, a, 0, 0, 0, "R6");
                step(0, 0, 0, 0, 0, "R6");
                step(0, 0, 0, 0, 0, "R8");
            end
        end
        nop(2, "R5");

        // R7: read and write to the same burst in one cycle
        for (int a = 0; a < 16; a++) begin
            step(1, a, 1, a, 1, "R7");
            step(0, 0, 0, 0, 0, "R7");
            step(1, a, 0, 0, 0, "R7");
            step(0, 0, 0, 0, 0, "R7");
        end
        nop(3, "R8");

        // R6: dense pseudo-random traffic on four bursts
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] r;
            r = rnd();
            step(r[3], int'(r[9:8]), r[5], int'(r[12:11]), 1, "R6");
        end
        nop(4, "R8");
        // R1 / R2: final read sweep of whole array
        for (int a = 0; a < 16; a++) begin
            step(1, a, 0, 0, 0, "R2");
            step(0, 0, 0, 0, 0, "R2");
        end
        nop(3, "R8");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule